// File: doc/BRIEF.md
# Two-Phase Handshake Latch Pipeline

An elastic first-in first-out pipeline built from a chain of identical stages that move bundled data with toggle (two-phase) handshaking. The producer places a word on `in_data` and then flips `in_req`. The pipeline takes the word and flips `in_ack`. At the far end the pipeline presents a word on `out_data` and flips `out_req`. The consumer reads it and flips `out_ack`. Every edge of a request or acknowledge, rising or falling, stands for exactly one item, so the protocol has no return-to-zero phase.

Each stage holds one phase bit and one data word. Its only control is an equality test (an XNOR) between its own phase and the phase coming back from the next stage. While the two are equal the stage is empty and open. When a new request phase arrives the stage captures the word and the phase. That captured phase is both its request to the next stage and its acknowledge to the previous one. The design is modelled in one clock domain. A shift register of `DLY` cycles on each stage's incoming request stands in for the matched bundling delay.

A stalled consumer lets the chain fill up to one item per stage. A stalled producer lets it drain. The relative speeds of the two ends do not affect correctness.

Top module: `tsp_pipe`

## Requirements
- R1: While reset is asserted and on release, `in_ack`, `out_req` and `out_data` are all 0, so the pipeline is empty.
- R2: Each item costs exactly one `in_ack` transition. Over any run, the count of `in_ack` toggles equals the count of `in_req` toggles the producer made, once the producer waits for `in_ack == in_req` before each new toggle.
- R3: Words leave on `out_data` in the order they entered, with none lost or repeated, under any mix of producer and consumer stalls.
- R4: The pipeline never holds more than `NSTAGE` items (accepted minus consumed). With the consumer stalled, it accepts exactly `NSTAGE` items and then withholds `in_ack`.
- R5: Into an empty pipeline, an `in_req` toggle made before clock edge 1 makes `out_req` toggle at edge `NSTAGE*(DLY+1)`, and not before.
- R6: While `out_req != out_ack`, `out_data` stays stable.
- R7: A stage whose phase differs from its successor's phase holds its phase and its word until the successor catches up.
- R8: Into an empty pipeline, `in_ack` toggles at edge `DLY+1` after an `in_req` toggle made before edge 1, and not before.
- R9: Changes on `in_data` while `in_req == in_ack` are ignored: they produce no `in_ack` or `out_req` transition and no item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | WIDTH | Word offered by the producer |
| in_req | input | 1 | Producer request; each toggle offers one word |
| in_ack | output | 1 | Acknowledge to the producer; each toggle takes one word |
| out_data | output | WIDTH | Word offered to the consumer |
| out_req | output | 1 | Request to the consumer; each toggle offers one word |
| out_ack | input | 1 | Consumer acknowledge; each toggle frees the last stage |

## Verification
An `in_req` toggle on an empty pipeline should show up on `in_ack` after `DLY+1` edges and on `out_req` after `NSTAGE*(DLY+1)` edges. The bench drives at falling edges and samples one edge before and exactly at each of those edges, so an early or a late result both fail. In the random phases every output is read at the falling edge that follows the edge that could have changed it. Occupancy is checked on every cycle, and each consumed word is compared against a scoreboard in order. The capacity and ignored-data checks each hold the relevant input for many times the pipeline latency before they sample.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
    // Stage controller: open (able to take a new phase) when own phase matches downstream phase
    function automatic logic stage_open(input logic own_ph, input logic nxt_ph);
        return ~(own_ph ^ nxt_ph);
    endfunction
endpackage

// File: rtl/tsp_delay.sv
module tsp_delay #(
    parameter int DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    output logic dst
);
    logic [DLY-1:0] sh_d, sh_q;

    generate
        if (DLY == 1) begin : g_one
            always_comb sh_d = src;
        end else begin : g_many
            always_comb sh_d = {sh_q[DLY-2:0], src};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dst = sh_q[DLY-1];
endmodule

// File: rtl/tsp_stage.sv
module tsp_stage
    import tsp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_dly,
    input  logic [WIDTH-1:0] up_data,
    input  logic             nxt_ph,
    output logic             ph,
    output logic [WIDTH-1:0] data
);
    typedef struct packed {
        logic             ph;
        logic [WIDTH-1:0] dat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stage_open(st_q.ph, nxt_ph) && (req_dly != st_q.ph)) begin
            st_d.ph  = req_dly;
            st_d.dat = up_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ph   = st_q.ph;
    assign data = st_q.dat;

    // R7: a full stage keeps its phase and word until the successor catches up
    a_r7_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != nxt_ph) |=> $stable(st_q));
endmodule

// File: rtl/tsp_pipe.sv
module tsp_pipe #(
    parameter int NSTAGE = 10,
    parameter int WIDTH  = 16,
    parameter int DLY    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_req,
    output logic             in_ack,
    output logic [WIDTH-1:0] out_data,
    output logic             out_req,
    input  logic             out_ack
);
    localparam int LAST = NSTAGE - 1;

    logic             ph_w    [NSTAGE];
    logic [WIDTH-1:0] dat_w   [NSTAGE];
    logic             src_req [NSTAGE];
    logic [WIDTH-1:0] src_dat [NSTAGE];
    logic             nx_ph   [NSTAGE];
    logic             req_dl  [NSTAGE];

    generate
        for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign src_req[g] = in_req;
                assign src_dat[g] = in_data;
            end else begin : g_body
                assign src_req[g] = ph_w[g-1];
                assign src_dat[g] = dat_w[g-1];
                // R4: a stage only takes a new phase while its predecessor holds a different one
                a_r4_take_from_full: assert property (@(posedge clk) disable iff (!rst_n)
                    (ph_w[g] != $past(ph_w[g])) |-> ($past(ph_w[g-1]) != $past(ph_w[g])));
            end
            if (g == LAST) begin : g_tail
                assign nx_ph[g] = out_ack;
            end else begin : g_mid
                assign nx_ph[g] = ph_w[g+1];
            end

            tsp_delay #(.DLY(DLY)) u_dly (
                .clk (clk),
                .rst_n (rst_n),
                .src (src_req[g]),
                .dst (req_dl[g])
            );

            tsp_stage #(.WIDTH(WIDTH)) u_stg (
                .clk     (clk),
                .rst_n   (rst_n),
                .req_dly (req_dl[g]),
                .up_data (src_dat[g]),
                .nxt_ph  (nx_ph[g]),
                .ph      (ph_w[g]),
                .data    (dat_w[g])
            );
        end
    endgenerate

    assign in_ack   = ph_w[0];
    assign out_req  = ph_w[LAST];
    assign out_data = dat_w[LAST];

    // R6: offered word is held until the consumer acknowledges it
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req != out_ack) |=> $stable(out_data));

    // R1: outputs are idle under reset
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (in_ack == 1'b0 && out_req == 1'b0);
        end
    end
endmodule

// File: tb/tb_tsp_pipe.sv
module tb_tsp_pipe;
    localparam int NSTAGE = 10;
    localparam int WIDTH  = 16;
    localparam int DLY    = 1;
    localparam int LAT    = NSTAGE * (DLY + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic             in_req = 1'b0;
    logic             out_ack = 1'b0;
    logic             in_ack, out_req;
    logic [WIDTH-1:0] out_data;

    always #5 clk = ~clk;

    tsp_pipe #(.NSTAGE(NSTAGE), .WIDTH(WIDTH), .DLY(DLY)) dut (
        .clk (clk), .rst_n (rst_n),
        .in_data (in_data), .in_req (in_req), .in_ack (in_ack),
        .out_data (out_data), .out_req (out_req), .out_ack (out_ack)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [WIDTH-1:0] exp_q [1024];
    int n_sent = 0;
    int n_got = 0;
    int n_acc = 0;
    logic last_ack = 1'b0;

    function automatic int occupancy(input int acc, input int got);
        return acc - got;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cyc(input int pst, input int cst, input bit push, input int limit);
        if (in_ack !== last_ack) begin
            n_acc++;
            last_ack = in_ack;
        end
        chk(occupancy(n_acc, n_got) <= NSTAGE, "R4 occupancy", occupancy(n_acc, n_got), NSTAGE);
        if (out_req !== out_ack && int'($urandom % 100) >= cst) begin
            chk(out_data === exp_q[n_got % 1024], "R3 order", int'(out_data), int'(exp_q[n_got % 1024]));
            n_got++;
            out_ack = ~out_ack;
        end
        if (push && in_ack === in_req && n_sent < limit && int'($urandom % 100) >= pst) begin
            in_data = WIDTH'($urandom);
            exp_q[n_sent % 1024] = in_data;
            n_sent++;
            in_req = ~in_req;
        end
        step(1);
    endtask

    task automatic drain();
        for (int k = 0; k < 4000 && n_got < n_sent; k++) cyc(0, 0, 1'b0, 0);
        step(2 * LAT);
        if (in_ack !== last_ack) begin
            n_acc++;
            last_ack = in_ack;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [WIDTH-1:0] held;
        void'($urandom(32'd1234));
        @(negedge clk);
        chk(in_ack === 1'b0 && out_req === 1'b0, "R1 reset handshake", {in_ack, out_req}, 0);
        step(3);
        rst_n = 1'b1;
        step(1);
        chk(out_data === '0 && in_ack === 1'b0 && out_req === 1'b0, "R1 after release",
            int'(out_data), 0);

        // Directed: latency into an empty pipeline (R8, R5)
        in_data = 16'hA5A5;
        exp_q[0] = in_data;
        n_sent = 1;
        in_req = 1'b1;
        step(DLY);
        chk(in_ack === 1'b0, "R8 in_ack not early", in_ack, 0);
        step(1);
        chk(in_ack === 1'b1, "R8 in_ack on time", in_ack, 1);
        n_acc = 1;
        last_ack = 1'b1;
        step(LAT - DLY - 2);
        chk(out_req === 1'b0, "R5 out_req not early", out_req, 0);
        step(1);
        chk(out_req === 1'b1, "R5 out_req on time", out_req, 1);
        chk(out_data === 16'hA5A5, "R3 first word", int'(out_data), 16'hA5A5);
        out_ack = 1'b1;
        n_got = 1;
        step(2);

        // R9: data changes without a request are ignored
        for (int k = 0; k < 3 * LAT; k++) begin
            in_data = WIDTH'($urandom);
            step(1);
        end
        chk(in_ack === 1'b1, "R9 no spurious in_ack", in_ack, 1);
        chk(out_req === 1'b1 && out_ack === 1'b1, "R9 no spurious out_req", out_req, 1);

        // R4/R7: stalled consumer, pipeline fills to exactly NSTAGE
        for (int k = 0; k < 300; k++) cyc(0, 100, 1'b1, n_sent + 50);
        chk(occupancy(n_acc, n_got) == NSTAGE, "R4 R7 capacity", occupancy(n_acc, n_got), NSTAGE);
        chk(in_req !== in_ack, "R4 in_ack withheld when full", in_ack, ~in_req);
        held = out_data;
        step(40);
        chk(out_data === held && out_req !== out_ack, "R6 out_data held", int'(out_data), int'(held));
        drain();
        chk(n_got == n_sent, "R3 capacity drain count", n_got, n_sent);

        // Random elastic traffic, several stall mixes
        for (int k = 0; k < 1500; k++) cyc(30, 40, 1'b1, 900);
        for (int k = 0; k < 800; k++) cyc(0, 70, 1'b1, 900);
        for (int k = 0; k < 800; k++) cyc(70, 0, 1'b1, 900);
        for (int k = 0; k < 600; k++) cyc(0, 0, 1'b1, 900);
        drain();
        chk(n_got == n_sent, "R3 no loss or duplicate", n_got, n_sent);
        chk(n_acc == n_sent, "R2 one in_ack toggle per item", n_acc, n_sent);
        chk(out_req === out_ack && in_ack === in_req, "R2 idle at end", {out_req, out_ack}, {in_req, in_req});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule